// File: doc/BRIEF.md
# Dual-Clock First-Word Fall-Through FIFO

A small first-in first-out buffer of 16 words by 4 bits that links two independent clock domains. A producer stores a word on a rising edge of the load clock while its load strobe is high. A consumer removes a word on a rising edge of the unload clock while its unload strobe is high. The oldest stored word is always on the data output, so the first word after an empty period can be read without an unload edge.

Occupancy is reported on two active-low flags. The full flag is computed in the load domain and the empty flag in the unload domain. Each domain sees the other's pointer as a Gray code through two synchronizer stages. A flag may therefore stay asserted a few cycles longer than the true state, but it never misses a true full or empty condition. An active-low reset is asserted asynchronously and released synchronously in each domain. An output-enable qualifies the data output in place of a high-impedance pad and has no effect on the flags.

Top module: `fall_fifo`

## Requirements
- R1: Words leave the buffer in the order they were stored, with their 4-bit values unchanged.
- R2: A load edge with `ld_en` high and `full_n` high stores `din`. After 16 more words have been stored than removed, `full_n` reads low. A load while `full_n` is low changes neither the stored data nor the write pointer.
- R3: An unload edge while `empty_n` is low has no effect. The next stored word is the next one presented.
- R4: `empty_n` is low when no word is held and high otherwise. Once both clocks have run a few cycles with no strobe, it matches the true occupancy.
- R5: While `rst_n` is low, both pointers are cleared, `empty_n` is low and `full_n` is high, without waiting for a clock edge.
- R6: After the first load following reset or an empty state, `empty_n` goes high and `q` shows that word with no unload edge.
- R7: `q_drv` follows `oe`. `oe` does not change `full_n`, `empty_n` or the stored words.
- R8: Each pointer's Gray form changes at most one bit per clock of its own domain.
- R9: The write pointer never runs more than 16 words ahead of the read pointer as seen in the load domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_clk | input | 1 | Load clock, rising edge |
| ld_en | input | 1 | Load strobe, synchronous to ld_clk |
| din | input | 4 | Word to store |
| ul_clk | input | 1 | Unload clock, rising edge |
| ul_en | input | 1 | Unload strobe, synchronous to ul_clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe | input | 1 | Output enable for q |
| q | output | 4 | Oldest stored word (fall-through) |
| q_drv | output | 1 | High when q is driven (models the enabled output) |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |

## Verification
The assertions take the following for granted about the inputs:
- Each strobe changes only between edges of its own clock.
- Both clocks run freely, so the synchronized pointers keep advancing.
- Reset is held low across at least one edge of each clock.

The bench keeps within these limits. It drives every strobe at the falling edge of its own clock. It waits a settle window on both clocks before it compares any flag with the reference queue, and it holds reset for several cycles. The unload clock period changes at random during the mixed phase, which exercises several clock ratios.

// File: rtl/fall_fifo.sv
module fall_fifo #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          ld_clk,
  input  logic          ld_en,
  input  logic [DW-1:0] din,
  input  logic          ul_clk,
  input  logic          ul_en,
  input  logic          rst_n,
  input  logic          oe,
  output logic [DW-1:0] q,
  output logic          q_drv,
  output logic          full_n,
  output logic          empty_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [1:0] ld_rs, ul_rs;
  logic       ld_rst_n, ul_rst_n;

  always_ff @(posedge ld_clk or negedge rst_n)
    if (!rst_n) ld_rs <= '0;
    else        ld_rs <= {ld_rs[0], 1'b1};

  always_ff @(posedge ul_clk or negedge rst_n)
    if (!rst_n) ul_rs <= '0;
    else        ul_rs <= {ul_rs[0], 1'b1};

  assign ld_rst_n = ld_rs[1];
  assign ul_rst_n = ul_rs[1];

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [PW-1:0] wbin_nx, rbin_nx;
  logic          wr_go, rd_go;

  assign wr_go   = ld_en & full_n;
  assign rd_go   = ul_en & empty_n;
  assign wbin_nx = wbin + PW'(1);
  assign rbin_nx = rbin + PW'(1);

  always_ff @(posedge ld_clk or negedge ld_rst_n)
    if (!ld_rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_go) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end

  always_ff @(posedge ld_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge ul_clk or negedge ul_rst_n)
    if (!ul_rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_go) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end

  always_ff @(posedge ld_clk or negedge ld_rst_n)
    if (!ld_rst_n) begin
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
    end

  always_ff @(posedge ul_clk or negedge ul_rst_n)
    if (!ul_rst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
    end

  assign full_n  = wgray != {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]};
  assign empty_n = rgray != wg_s2;
  assign q       = mem[rbin[AW-1:0]];
  assign q_drv   = oe;
endmodule

// File: rtl/fall_fifo_chk.sv
module fall_fifo_chk #(
  parameter int AW = 4
) (
  input logic          ld_clk,
  input logic          ul_clk,
  input logic          rst_n,
  input logic          ld_rst_n,
  input logic          ul_rst_n,
  input logic          ld_en,
  input logic          ul_en,
  input logic          full_n,
  input logic          empty_n,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [AW:0]   rg_s2
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rb_seen;
  always_comb begin
    rb_seen[PW-1] = rg_s2[PW-1];
    for (int i = PW - 2; i >= 0; i--) rb_seen[i] = rb_seen[i+1] ^ rg_s2[i];
  end

  // R2: a load while full leaves the write pointer where it was
  a_r2_full_blocks: assert property (@(posedge ld_clk) disable iff (!ld_rst_n)
    (!full_n && ld_en) |=> $stable(wbin));

  // R3: an unload while empty leaves the read pointer where it was
  a_r3_empty_blocks: assert property (@(posedge ul_clk) disable iff (!ul_rst_n)
    (!empty_n && ul_en) |=> $stable(rbin));

  // R5: flags under reset
  a_r5_reset_flags: assert property (@(posedge ul_clk)
    !rst_n |-> (!empty_n && full_n));

  // R8: single-bit Gray steps
  a_r8_wgray_step: assert property (@(posedge ld_clk) disable iff (!ld_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  a_r8_rgray_step: assert property (@(posedge ul_clk) disable iff (!ul_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  // R9: no overflow beyond the depth
  a_r9_no_overflow: assert property (@(posedge ld_clk) disable iff (!ld_rst_n)
    (wbin - rb_seen) <= PW'(DEPTH));
endmodule

bind fall_fifo fall_fifo_chk #(.AW(AW)) u_chk (
  .ld_clk(ld_clk), .ul_clk(ul_clk), .rst_n(rst_n),
  .ld_rst_n(ld_rst_n), .ul_rst_n(ul_rst_n),
  .ld_en(ld_en), .ul_en(ul_en), .full_n(full_n), .empty_n(empty_n),
  .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray), .rg_s2(rg_s2)
);

// File: tb/test_fall_fifo.sv
`timescale 1ns/1ps
module test_fall_fifo;
  logic ld_clk = 0, ul_clk = 0, ld_en = 0, ul_en = 0, rst_n = 0, oe = 1;
  logic [3:0] din = 0;
  logic [3:0] q;
  logic q_drv, full_n, empty_n;
  int n_chk = 0, n_err = 0, ul_half = 3;
  logic [3:0] model [$];

  localparam logic [3:0] VEC [16] = '{4'h3, 4'hA, 4'h5, 4'hC, 4'h0, 4'hF, 4'h9, 4'h6,
                                      4'h1, 4'hE, 4'h7, 4'h8, 4'h2, 4'hD, 4'hB, 4'h4};

  fall_fifo i_fall_fifo (.ld_clk(ld_clk), .ld_en(ld_en), .din(din), .ul_clk(ul_clk),
    .ul_en(ul_en), .rst_n(rst_n), .oe(oe), .q(q), .q_drv(q_drv),
    .full_n(full_n), .empty_n(empty_n));

  always #2 ld_clk = ~ld_clk;
  always begin #(ul_half); ul_clk = ~ul_clk; end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge ld_clk);
    repeat (6) @(posedge ul_clk);
    @(negedge ul_clk);
  endtask

  task automatic push(logic [3:0] d);
    logic acc;
    @(negedge ld_clk);
    din = d; ld_en = 1; acc = full_n;
    @(negedge ld_clk);
    ld_en = 0;
    if (acc) model.push_back(d);
  endtask

  task automatic pop();
    @(negedge ul_clk);
    if (empty_n && model.size() > 0) begin
      chk("R1 data order", 8'(q), 8'(model[0]));
      void'(model.pop_front());
      ul_en = 1;
    end
    @(negedge ul_clk);
    ul_en = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #700000;
    n_err++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    chk("R5 empty_n in reset", 8'(empty_n), 8'd0);
    chk("R5 full_n in reset", 8'(full_n), 8'd1);
    repeat (5) @(posedge ul_clk);
    @(negedge ld_clk); rst_n = 1;
    settle();

    foreach (VEC[i]) begin
      push(VEC[i]);
      if (i == 0) begin
        settle();
        chk("R6 fall-through flag", 8'(empty_n), 8'd1);
        chk("R6 fall-through data", 8'(q), 8'(VEC[0]));
        chk("R2 not yet full", 8'(full_n), 8'd1);
      end
    end
    settle();
    chk("R2 full flag", 8'(full_n), 8'd0);
    push(4'hF);
    chk("R2 overflow rejected", 8'(model.size()), 8'd16);
    settle();
    chk("R2 head unchanged while full", 8'(q), 8'(VEC[0]));
    for (int i = 0; i < 16; i++) pop();
    settle();
    chk("R4 empty after drain", 8'(empty_n), 8'd0);
    chk("R2 full released", 8'(full_n), 8'd1);

    for (int i = 0; i < 3; i++) begin
      @(negedge ul_clk); ul_en = 1;
      @(negedge ul_clk); ul_en = 0;
    end
    push(4'h6);
    settle();
    chk("R3 unload while empty ignored", 8'(q), 8'h6);
    chk("R4 not empty", 8'(empty_n), 8'd1);
    pop();
    settle();
    chk("R4 empty again", 8'(empty_n), 8'd0);

    oe = 0;
    push(4'h9);
    settle();
    chk("R7 q_drv low", 8'(q_drv), 8'd0);
    chk("R7 empty_n ignores oe", 8'(empty_n), 8'd1);
    chk("R7 full_n ignores oe", 8'(full_n), 8'd1);
    oe = 1;
    #1;
    chk("R7 q_drv high", 8'(q_drv), 8'd1);
    chk("R7 word kept", 8'(q), 8'h9);

    push(4'h1); push(4'h2);
    settle();
    @(negedge ld_clk); rst_n = 0;
    #1;
    chk("R5 async empty", 8'(empty_n), 8'd0);
    chk("R5 async full", 8'(full_n), 8'd1);
    model.delete();
    repeat (4) @(posedge ul_clk);
    @(negedge ld_clk); rst_n = 1;
    settle();
    chk("R5 empty after release", 8'(empty_n), 8'd0);

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 40 == 0) ul_half = 1 + int'($urandom % 5);
      if ($urandom % 2 == 0) push(4'($urandom));
      else pop();
    end
    settle();
    for (int g = 0; g < 4000 && model.size() > 0; g++) pop();
    settle();
    chk("R4 empty after random drain", 8'(empty_n), 8'd0);
    chk("R1 model drained", 8'(model.size()), 8'd0);
    finish_run();
  end
endmodule